// File: doc/BRIEF.md
# Grouped Three-Level Interrupt Controller

This block gathers interrupt requests into three groups and ranks them. The critical group is fed by four external request pins. The main group is fed by a vector of on-chip sources. The peripheral group is fed by a second vector of on-chip sources. Software controls the block over a small 32-bit register bus with four word addresses:

| Address | Register |
|---|---|
| 0 | External-pin control |
| 1 | Main-group mask |
| 2 | Peripheral-group mask |
| 3 | Read-only encoded status word |

A single output tells the processor that some enabled request is pending. Software then reads the status word to learn which group won and which source number inside each group is pending.

Each external pin has its own enable bit, a two-bit sense type and a write-one-to-clear acknowledge bit. All three live in the one control register at bit offsets computed from the pin number. In both mask registers a 1 blocks the source. The masks come out of reset with every implemented source blocked.

Two peripheral sources can be boosted, each through a parameter. A pending boosted source also raises a virtual slot in the main group, slot 2 for high boost and slot 4 for low boost. The peripheral field of the status word still names the real source.

All source inputs and pins are first captured in flops. The status word and the interrupt output are combinational from those captured values and from the configuration registers. There is no state machine: the only sequential state is the captured inputs, the edge latches and the configuration registers.

Top module: `tlic_top`

## Requirements
- R1: After reset, the control register reads 0. The main mask reads 0x00010FFF. The peripheral mask reads 0x7FFFFC00. The status word reads 0 and irq_out is low.
- R2: For pin n (0..3), control bit (11-n) is the enable and bits [23-2n:22-2n] are the sense type. Both read back as written. Acknowledge bits (27-n) and all other control bits read 0.
- R3: The sense codes are 00 = level high, 01 = rising edge, 10 = falling edge and 11 = level low. A level type follows the pin value captured at the last clock edge.
- R4: An edge type latches its request, and the request stays until software writes 1 to control bit (27-n). If a new edge arrives in the same cycle as the acknowledge, the new edge wins.
- R5: A pin is reported in the critical group only while its enable bit is 1. The critical number is the pin number.
- R6: Main source n (0..16) is blocked when main mask bit (16-n) is 1. Only sources 0 and 5..16 come from main_src. main_src bits 1..4 have no effect. Main mask bits 31..17 read 0.
- R7: Peripheral source n (0..21) is blocked when peripheral mask bit (31-n) is 1. per_src bit 0 has no effect. Peripheral mask bits 9..0 read 0.
- R8: Within each group, the lowest-numbered pending, unblocked source wins. The status word carries valid flags and 5-bit numbers, with the layout shown after this list. A number field reads 0 when its group is not valid.
- R9: Status bits [1:0] give the winning group: 0 = none, 1 = critical, 2 = main, 3 = peripheral. Critical wins over main, and main wins over peripheral.
- R10: A pending, unblocked peripheral source in the high-boost set raises main slot 2. One in the low-boost set raises main slot 4. Both slots obey main mask bits 14 and 12. The peripheral field still reports the real source.
- R11: irq_out is high exactly when at least one of the three valid flags is set.
- R12: Writes to address 3 change nothing. A change on a source input shows in the status word only after the next rising clock edge.

Status word layout (R8):

| Bits | Meaning |
|---|---|
| 31 | Critical valid |
| 30 | Main valid |
| 29 | Peripheral valid |
| [28:24] | Critical number |
| [20:16] | Main number |
| [12:8] | Peripheral number |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, with bus_en |
| bus_addr | input | 2 | Word address: 0 control, 1 main mask, 2 peripheral mask, 3 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| ext_pin | input | 4 | External request pins |
| main_src | input | 17 | Main-group source requests |
| per_src | input | 22 | Peripheral-group source requests |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
Every visible result is due exactly one rising edge after its cause. A register write is captured at that edge and can then be read back. A pin or source change is captured at the next edge and only then shows in the status word and on irq_out. A write of 1 to an acknowledge bit clears the latch at the edge that captures the write. The bench drives every input 2 ns after a rising edge and samples after the following edge. Bus reads are combinational, so the bench samples them 1 ns after setting the address. The latency check looks at the status word both before and after the capturing edge.

// File: rtl/tlic_pkg.sv
package tlic_pkg;
    localparam int DW     = 32;
    localparam int EXT_N  = 4;
    localparam int MAIN_N = 17;
    localparam int PER_N  = 22;
    localparam int NUM_W  = 5;

    // control register field bases; pin n sits at base minus n (or 2n)
    localparam int EN_BASE    = 11;
    localparam int ACK_BASE   = 27;
    localparam int SENSE_BASE = 22;

    localparam logic [DW-1:0]     MAIN_MASK_RST = 32'h0001_0FFF;
    localparam logic [DW-1:0]     PER_MASK_RST  = 32'h7FFF_FC00;
    localparam int                PER_MASK_LSB  = DW - PER_N;

    // main slots fed from main_src; slots 2 and 4 carry boosted peripherals
    localparam logic [MAIN_N-1:0] MAIN_IMPL  = 17'h1FFE1;
    localparam logic [PER_N-1:0]  PER_IMPL   = 22'h3FFFFE;
    localparam int                SLOT_BHI   = 2;
    localparam int                SLOT_BLO   = 4;

    typedef enum logic [1:0] {
        SENSE_LVL_HI = 2'b00,
        SENSE_RISE   = 2'b01,
        SENSE_FALL   = 2'b10,
        SENSE_LVL_LO = 2'b11
    } sense_e;

    typedef enum logic [1:0] {
        GRP_NONE = 2'd0,
        GRP_CRIT = 2'd1,
        GRP_MAIN = 2'd2,
        GRP_PER  = 2'd3
    } grp_e;

    typedef enum logic [1:0] {
        A_CTRL  = 2'd0,
        A_MMASK = 2'd1,
        A_PMASK = 2'd2,
        A_STAT  = 2'd3
    } addr_e;
endpackage

// File: rtl/tlic_ext_sense.sv
module tlic_ext_sense
    import tlic_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pin,
    input  sense_e mode,
    input  logic   ack,
    output logic   req
);
    logic pin_q;
    logic lat_q;
    logic hit;

    always_comb begin
        hit = ((mode == SENSE_RISE) &&  pin && !pin_q) ||
              ((mode == SENSE_FALL) && !pin &&  pin_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
            lat_q <= 1'b0;
        end else begin
            pin_q <= pin;
            lat_q <= hit | (lat_q & ~ack);
        end
    end

    always_comb begin
        unique case (mode)
            SENSE_LVL_HI: req = pin_q;
            SENSE_LVL_LO: req = ~pin_q;
            default:      req = lat_q;
        endcase
    end

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !hit) |=> !lat_q); // R4
    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_q && !ack) |=> lat_q); // R4
endmodule

// File: rtl/tlic_lowfind.sv
module tlic_lowfind #(
    parameter int N = 17,
    parameter int W = 5
) (
    input  logic [N-1:0] req,
    output logic         hit,
    output logic [W-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                hit = 1'b1;
                idx = W'(i);
            end
        end
    end
endmodule

// File: rtl/tlic_top.sv
module tlic_top
    import tlic_pkg::*;
#(
    parameter logic [PER_N-1:0] BOOST_HI = '0,
    parameter logic [PER_N-1:0] BOOST_LO = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_en,
    input  logic             bus_we,
    input  logic [1:0]       bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [EXT_N-1:0] ext_pin,
    input  logic [MAIN_N-1:0] main_src,
    input  logic [PER_N-1:0] per_src,
    output logic             irq_out
);
    addr_e               addr;
    logic                wr;
    logic [EXT_N-1:0]    ext_en;
    sense_e              ext_mode [EXT_N];
    logic [EXT_N-1:0]    ext_ack;
    logic [EXT_N-1:0]    ext_req;
    logic [MAIN_N-1:0]   mmask_q;
    logic [PER_N-1:0]    pmask_q;
    logic [MAIN_N-1:0]   main_q;
    logic [PER_N-1:0]    per_q;
    logic [EXT_N-1:0]    crit_live;
    logic [MAIN_N-1:0]   main_live;
    logic [PER_N-1:0]    per_live;
    logic                crit_v, main_v, per_v;
    logic [NUM_W-1:0]    crit_idx, main_idx, per_idx;
    grp_e                grp;
    logic [DW-1:0]       ctrl_rd, stat;
    logic                unused_ok;

    assign addr = addr_e'(bus_addr);
    assign wr   = bus_en & bus_we;

    // configuration registers and input capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_en  <= '0;
            for (int n = 0; n < EXT_N; n++) ext_mode[n] <= SENSE_LVL_HI;
            mmask_q <= MAIN_MASK_RST[MAIN_N-1:0];
            pmask_q <= PER_MASK_RST[DW-1:PER_MASK_LSB];
            main_q  <= '0;
            per_q   <= '0;
        end else begin
            main_q <= main_src;
            per_q  <= per_src;
            if (wr && addr == A_CTRL) begin
                for (int n = 0; n < EXT_N; n++) begin
                    ext_en[n]   <= bus_wdata[EN_BASE-n];
                    ext_mode[n] <= sense_e'(bus_wdata[SENSE_BASE-2*n +: 2]);
                end
            end
            if (wr && addr == A_MMASK) mmask_q <= bus_wdata[MAIN_N-1:0];
            if (wr && addr == A_PMASK) pmask_q <= bus_wdata[DW-1:PER_MASK_LSB];
        end
    end

    genvar g;
    generate
        for (g = 0; g < EXT_N; g++) begin : g_ext
            assign ext_ack[g] = wr && (addr == A_CTRL) && bus_wdata[ACK_BASE-g];
            tlic_ext_sense u_sense (
                .clk  (clk),
                .rst_n(rst_n),
                .pin  (ext_pin[g]),
                .mode (ext_mode[g]),
                .ack  (ext_ack[g]),
                .req  (ext_req[g])
            );
            assign crit_live[g] = ext_req[g] & ext_en[g];
        end

        for (g = 0; g < PER_N; g++) begin : g_per
            if (PER_IMPL[g]) begin : g_on
                assign per_live[g] = per_q[g] & ~pmask_q[PER_N-1-g];
            end else begin : g_off
                assign per_live[g] = 1'b0;
            end
        end

        for (g = 0; g < MAIN_N; g++) begin : g_main
            if (g == SLOT_BHI) begin : g_bhi
                assign main_live[g] = (|(per_live & BOOST_HI)) & ~mmask_q[MAIN_N-1-g];
            end else if (g == SLOT_BLO) begin : g_blo
                assign main_live[g] = (|(per_live & BOOST_LO)) & ~mmask_q[MAIN_N-1-g];
            end else if (MAIN_IMPL[g]) begin : g_on
                assign main_live[g] = main_q[g] & ~mmask_q[MAIN_N-1-g];
            end else begin : g_off
                assign main_live[g] = 1'b0;
            end
        end
    endgenerate

    assign unused_ok = ^(main_q & ~MAIN_IMPL) ^ ^(per_q & ~PER_IMPL);

    tlic_lowfind #(.N(EXT_N),  .W(NUM_W)) u_crit (.req(crit_live), .hit(crit_v), .idx(crit_idx));
    tlic_lowfind #(.N(MAIN_N), .W(NUM_W)) u_main (.req(main_live), .hit(main_v), .idx(main_idx));
    tlic_lowfind #(.N(PER_N),  .W(NUM_W)) u_per  (.req(per_live),  .hit(per_v),  .idx(per_idx));

    always_comb begin
        if (crit_v)      grp = GRP_CRIT;
        else if (main_v) grp = GRP_MAIN;
        else if (per_v)  grp = GRP_PER;
        else             grp = GRP_NONE;
    end

    assign stat = {crit_v, main_v, per_v, crit_idx, 3'b000, main_idx, 3'b000,
                   per_idx, 6'b000000, grp};

    always_comb begin
        ctrl_rd = '0;
        for (int n = 0; n < EXT_N; n++) begin
            ctrl_rd[EN_BASE-n]             = ext_en[n];
            ctrl_rd[SENSE_BASE-2*n +: 2]   = ext_mode[n];
        end
    end

    always_comb begin
        unique case (addr)
            A_CTRL:  bus_rdata = ctrl_rd;
            A_MMASK: bus_rdata = {{(DW-MAIN_N){1'b0}}, mmask_q};
            A_PMASK: bus_rdata = {pmask_q, {PER_MASK_LSB{1'b0}}};
            default: bus_rdata = stat;
        endcase
    end

    assign irq_out = crit_v | main_v | per_v;

    AST_IRQ_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (grp != GRP_NONE)); // R11
    AST_CRIT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        crit_v |-> grp == GRP_CRIT); // R9
    AST_BOOST_BACKED: assert property (@(posedge clk) disable iff (!rst_n)
        (main_v && (main_idx == NUM_W'(SLOT_BHI) || main_idx == NUM_W'(SLOT_BLO))) |-> per_v); // R10
    AST_STAT_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_STAT) |=> ($stable(mmask_q) && $stable(pmask_q) && $stable(ext_en))); // R12
endmodule

// File: tb/tlic_top_tb.sv
module tlic_top_tb;
    import tlic_pkg::*;

    localparam logic [PER_N-1:0] BHI_P = 22'h000020; // source 5
    localparam logic [PER_N-1:0] BLO_P = 22'h000080; // source 7

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_en = 1'b0, bus_we = 1'b0;
    logic [1:0]        bus_addr = 2'd0;
    logic [31:0]       bus_wdata = '0, bus_rdata;
    logic [EXT_N-1:0]  ext_pin = '0;
    logic [MAIN_N-1:0] main_src = '0;
    logic [PER_N-1:0]  per_src = '0;
    logic              irq_out;

    int nchk = 0;
    int nfail = 0;

    tlic_top #(.BOOST_HI(BHI_P), .BOOST_LO(BLO_P)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_pin(ext_pin), .main_src(main_src), .per_src(per_src),
        .irq_out(irq_out)
    );

    always #4 clk = ~clk;

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual hung expected finished");
        report();
        $finish;
    end

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 2'(a); bus_wdata = d;
        tick();
        bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = 2'(a);
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] mk(input bit cv, input int cn, input bit mv, input int mn,
                                       input bit pv, input int pn);
        logic [1:0] gc;
        gc = cv ? 2'd1 : mv ? 2'd2 : pv ? 2'd3 : 2'd0;
        return {cv, mv, pv, cv ? 5'(cn) : 5'd0, 3'b000, mv ? 5'(mn) : 5'd0, 3'b000,
                pv ? 5'(pn) : 5'd0, 6'b000000, gc};
    endfunction

    task automatic chk_stat(input string tag, input logic [31:0] exp);
        logic [31:0] v;
        rd(3, v);
        check32(tag, v, exp);
        check32({tag, " irq_out"}, {31'b0, irq_out}, {31'b0, |exp[31:29]});
    endtask

    function automatic int lowest(input logic [31:0] v);
        for (int i = 31; i >= 0; i--) if (v[i]) lowest = i;
        if (v == 0) lowest = -1;
    endfunction

    // bench model of one pin
    bit m_pin, m_lat;
    int m_mode;

    task automatic ext_step(input int n, input bit newpin, input bit ack, input logic [31:0] ctrlv);
        bit hit;
        hit = (m_mode == 1 && newpin && !m_pin) || (m_mode == 2 && !newpin && m_pin);
        ext_pin[n] = newpin;
        if (ack) wr(0, ctrlv | (32'h1 << (27 - n)));
        else     tick();
        m_lat = hit | (m_lat & !ack);
        m_pin = newpin;
    endtask

    function automatic bit m_req();
        case (m_mode)
            0: return m_pin;
            3: return !m_pin;
            default: return m_lat;
        endcase
    endfunction

    initial begin
        logic [31:0] v;
        logic [31:0] cfg;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset values
        rd(0, v); check32("R1 ctrl reset", v, 32'h0);
        rd(1, v); check32("R1 main mask reset", v, 32'h0001_0FFF);
        rd(2, v); check32("R1 per mask reset", v, 32'h7FFF_FC00);
        chk_stat("R1 status reset", 32'h0);

        // R2 control layout readback
        wr(0, 32'hFFFF_FFFF); rd(0, v); check32("R2 ctrl all ones", v, 32'h00FF_0F00);
        wr(0, 32'h0F1B_0500); rd(0, v); check32("R2 ctrl pattern", v, 32'h001B_0500);
        wr(0, 32'h0F00_0000); rd(0, v); check32("R2 ack reads zero", v, 32'h0);

        // R3 R4 sweep over pins and sense codes
        for (int n = 0; n < EXT_N; n++) begin
            for (int s = 0; s < 4; s++) begin
                cfg = (32'h1 << (11 - n)) | (32'(s) << (22 - 2 * n));
                wr(0, cfg | 32'h0F00_0000);
                m_pin = 1'b0; m_lat = 1'b0; m_mode = s;
                chk_stat($sformatf("R3 pin%0d sense%0d idle", n, s), m_req() ? mk(1, n, 0, 0, 0, 0) : 32'h0);
                ext_step(n, 1'b1, 1'b0, cfg);
                chk_stat($sformatf("R3 pin%0d sense%0d high", n, s), m_req() ? mk(1, n, 0, 0, 0, 0) : 32'h0);
                ext_step(n, 1'b0, 1'b0, cfg);
                chk_stat($sformatf("R4 pin%0d sense%0d held", n, s), m_req() ? mk(1, n, 0, 0, 0, 0) : 32'h0);
                ext_step(n, 1'b0, 1'b1, cfg);
                chk_stat($sformatf("R4 pin%0d sense%0d acked", n, s), m_req() ? mk(1, n, 0, 0, 0, 0) : 32'h0);
            end
        end
        // R4 edge in the same cycle as acknowledge wins
        wr(0, 32'h0000_0800 | 32'h0040_0000 | 32'h0800_0000); // pin0 rising, enabled
        ext_pin[0] = 1'b1;
        wr(0, 32'h0000_0800 | 32'h0040_0000 | 32'h0800_0000);
        chk_stat("R4 edge beats ack", mk(1, 0, 0, 0, 0, 0));
        ext_pin[0] = 1'b0;
        wr(0, 32'h0F00_0000);

        // R5 enable gating
        ext_pin = 4'hF; tick();
        chk_stat("R5 all disabled", 32'h0);
        wr(0, 32'h0000_0200); chk_stat("R5 only pin2", mk(1, 2, 0, 0, 0, 0));
        wr(0, 32'h0000_0F00); chk_stat("R5 all enabled", mk(1, 0, 0, 0, 0, 0));
        ext_pin = 4'h0; tick(); chk_stat("R5 pins low", 32'h0);
        wr(0, 32'h0);

        // R6 main group mask positions
        wr(1, 32'hFFFF_FFFF); rd(1, v); check32("R6 main mask width", v, 32'h0001_FFFF);
        wr(1, 32'h0); wr(2, 32'hFFFF_FFFF);
        rd(2, v); check32("R7 per mask width", v, 32'hFFFF_FC00);
        for (int n = 0; n < MAIN_N; n++) begin
            bit impl;
            impl = (n == 0) || (n >= 5);
            main_src = 17'(1) << n; tick();
            chk_stat($sformatf("R6 main src %0d", n), impl ? mk(0, 0, 1, n, 0, 0) : 32'h0);
            if (impl) begin
                wr(1, 32'h1 << (16 - n));
                chk_stat($sformatf("R6 main src %0d masked", n), 32'h0);
                wr(1, ~(32'h1 << (16 - n)) & 32'h0001_FFFF);
                chk_stat($sformatf("R6 main src %0d others masked", n), mk(0, 0, 1, n, 0, 0));
                wr(1, 32'h0);
            end
        end
        main_src = '0;

        // R7 peripheral group mask positions
        wr(1, 32'h0001_FFFF); wr(2, 32'h0);
        for (int n = 0; n < PER_N; n++) begin
            per_src = 22'(1) << n; tick();
            chk_stat($sformatf("R7 per src %0d", n), (n >= 1) ? mk(0, 0, 0, 0, 1, n) : 32'h0);
            if (n >= 1) begin
                wr(2, 32'h1 << (31 - n));
                chk_stat($sformatf("R7 per src %0d masked", n), 32'h0);
                wr(2, 32'h0);
            end
        end
        per_src = '0;

        // R8 priority sweeps
        wr(1, 32'h0); wr(2, 32'hFFFF_FFFF);
        for (int k = 0; k < 48; k++) begin
            logic [16:0] pat;
            int lo;
            pat = 17'((k * 32'h9E37) ^ (k * k * 7));
            lo = lowest({15'b0, pat & MAIN_IMPL});
            main_src = pat; tick();
            chk_stat($sformatf("R8 main pattern %h", pat), (lo >= 0) ? mk(0, 0, 1, lo, 0, 0) : 32'h0);
        end
        main_src = '0;
        wr(1, 32'h0001_FFFF); wr(2, 32'h0);
        for (int k = 0; k < 48; k++) begin
            logic [21:0] pat;
            int lo;
            pat = 22'((k * 32'h2F1B3) ^ (k << 9));
            lo = lowest({10'b0, pat & PER_IMPL});
            per_src = pat; tick();
            chk_stat($sformatf("R8 per pattern %h", pat), (lo >= 0) ? mk(0, 0, 0, 0, 1, lo) : 32'h0);
        end
        per_src = '0;

        // R10 boosted peripherals
        wr(1, 32'h0); wr(2, 32'h0);
        per_src = 22'h000020; tick(); chk_stat("R10 high boost", mk(0, 0, 1, 2, 1, 5));
        per_src = 22'h000080; tick(); chk_stat("R10 low boost", mk(0, 0, 1, 4, 1, 7));
        per_src = 22'h000028; tick(); chk_stat("R10 boost with lower per", mk(0, 0, 1, 2, 1, 3));
        per_src = 22'h0000A0; tick(); chk_stat("R10 both boosts", mk(0, 0, 1, 2, 1, 5));
        wr(1, 32'h0000_4000);
        per_src = 22'h000020; tick(); chk_stat("R10 slot2 masked", mk(0, 0, 0, 0, 1, 5));
        wr(1, 32'h0); wr(2, 32'h0400_0000);
        chk_stat("R10 source masked", 32'h0);
        per_src = '0; wr(2, 32'h0); tick();

        // R9 group ranking
        wr(0, 32'h0000_0400);
        ext_pin = 4'h2; main_src = 17'h00200; per_src = 22'h001000; tick();
        chk_stat("R9 all groups", mk(1, 1, 1, 9, 1, 12));
        ext_pin = 4'h0; tick(); chk_stat("R9 main over per", mk(0, 0, 1, 9, 1, 12));
        main_src = '0; tick(); chk_stat("R9 per alone", mk(0, 0, 0, 0, 1, 12));
        per_src = '0; tick(); chk_stat("R9 none", 32'h0);
        wr(0, 32'h0);

        // R12 status not writable, one-edge latency
        wr(1, 32'h0000_00F0); wr(2, 32'h0000_0C00);
        wr(3, 32'hFFFF_FFFF);
        rd(1, v); check32("R12 main mask kept", v, 32'h0000_00F0);
        rd(2, v); check32("R12 per mask kept", v, 32'h0000_0C00);
        rd(0, v); check32("R12 ctrl kept", v, 32'h0);
        chk_stat("R12 status still zero", 32'h0);
        main_src = 17'h00040;
        chk_stat("R12 before edge", 32'h0);
        tick();
        chk_stat("R12 after edge", mk(0, 0, 1, 6, 0, 0));
        main_src = '0; tick();

        report();
        $finish;
    end
endmodule